// File: doc/BRIEF.md
# Successive-Approximation Result Register with Nibble Bus Outputs

This block sequences a 12-bit successive-approximation conversion and holds the resulting code for a shared data bus. A one-cycle start pulse begins a conversion. The block raises its end-of-conversion flag and then sends one trial code per clock to an external DAC. It reads a comparator verdict on each trial. Bits are decided from the most significant downward. When the last bit is decided, the flag drops and the final code is captured in a result register.

The bus side is split into three 4-bit groups. Each group has its own active-low enable, and a disabled group leaves its lines released (high impedance). While a conversion runs, the bus lines carry the live, still-changing trial code, so a reader must not treat them as valid. Once the flag falls, they carry the captured word, which stays fixed through the following acquisition period. The enables can be tied to the flag so that the bus is released during conversion and driven afterwards.

A coding input selects how the code is read. In unipolar mode the code is straight binary. In bipolar mode it is offset binary, and a signed two's-complement view of the result is also provided.

Top module: `sar_nibble_reg`

## Requirements
- R1: After reset, `eoc` is 0, `dac_code` is 0, `twos_q` is 0 and the bus carries 0 on every enabled group.
- R2: A `start` sampled high while `eoc` is 0 sets `eoc` to 1 on the next clock, with `dac_code` equal to 0x800 (only the MSB set). `eoc` then stays high for exactly 12 clock cycles.
- R3: On each conversion clock, the bit under trial is kept when `cmp_ge` is 1 (input at or above the DAC level) and cleared when it is 0, and the next lower bit is then set for trial. The final code is the largest code not above the input.
- R4: A `start` pulse while `eoc` is 1 is ignored: the conversion is neither restarted nor lengthened, and its result is unchanged.
- R5: The result register loads only on the clock where `eoc` falls. While `eoc` is 0, the bus shows that word unchanged, whatever `cmp_ge` does.
- R6: While `eoc` is 1, the bus lines carry the live trial code, equal to `dac_code`.
- R7: Bus bit 1 (MSB) is `bus_q[11]` and bit 12 (LSB) is `bus_q[0]`. `oe_n[0]` gates bits 1-4 (`bus_q[11:8]`), `oe_n[1]` gates bits 5-8 (`bus_q[7:4]`) and `oe_n[2]` gates bits 9-12 (`bus_q[3:0]`). A 0 drives the group and a 1 releases it to high impedance, each group independently of the others.
- R8: With `bipolar` = 0 the code is straight binary: an input of zero gives 0x000 and full scale minus 1 LSB gives 0xFFF. `twos_q` is 0.
- R9: With `bipolar` = 1 the code is offset binary: negative full scale gives 0x000, zero gives 0x800 and positive full scale minus 1 LSB gives 0xFFF. `twos_q` equals the code with its MSB inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-trial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled while idle |
| cmp_ge | input | 1 | Comparator: 1 when input is at or above the DAC level |
| bipolar | input | 1 | 0 = straight binary, 1 = offset binary coding |
| oe_n | input | 3 | Active-low group enables (index 0 = MSB nibble) |
| dac_code | output | 12 | Trial code sent to the DAC |
| eoc | output | 1 | High while a conversion is in progress |
| bus_q | output | 12 | Three-state result bus, bit 11 = MSB |
| twos_q | output | 12 | Two's-complement view in bipolar mode, else 0 |

## Verification
The bench converts both end points of each coding (0x000 and 0xFFF) and values one LSB from them. A sequencer that clears a bit on a tie, or that skips the last trial, returns a code one below the input or with its LSB stuck. It pulses start in the middle of a conversion, which a design that restarts would show as a longer flag or a wrong code. It holds the comparator high during acquisition to catch a result register that keeps following the live trial code. Each group enable is switched on its own, with pull-ups on the bus, so a crossed nibble mapping or a group that stays driven shows up in the wrong position.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int unsigned SAR_MAXW = 32;

  typedef logic [SAR_MAXW-1:0] sar_word_t;

  // One bit trial: settle bit idx from the verdict, then arm bit idx-1.
  function automatic sar_word_t sar_step(sar_word_t code, int unsigned idx, logic keep);
    sar_word_t nxt;
    nxt = code;
    if (!keep) nxt[idx] = 1'b0;
    if (idx != 0) nxt[idx-1] = 1'b1;
    return nxt;
  endfunction

  // Offset binary to two's complement: flip the top bit of a width-w code.
  function automatic sar_word_t sar_offset_to_twos(sar_word_t code, int unsigned w);
    sar_word_t r;
    r = code;
    r[w-1] = ~code[w-1];
    return r;
  endfunction

endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int unsigned NBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_ge,
  output logic             busy,
  output logic [NBITS-1:0] trial,
  output logic             done,
  output logic [NBITS-1:0] final_code
);
  localparam int unsigned IW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int unsigned CW = IW + 1;

  logic [IW-1:0]    idx;
  logic [NBITS-1:0] step_code;

  always_comb begin
    sar_word_t w;
    w = sar_step(sar_word_t'(trial), int'(idx), cmp_ge);
    step_code = w[NBITS-1:0];
  end

  assign done       = busy && (idx == '0);
  assign final_code = step_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      trial <= '0;
      idx   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        trial <= {1'b1, {(NBITS-1){1'b0}}};
        idx   <= IW'(NBITS-1);
      end
    end else begin
      trial <= step_code;
      if (idx == '0) busy <= 1'b0;
      else           idx  <= idx - 1'b1;
    end
  end

  // checker counter: cycles spent busy
  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_cnt <= '0;
    else if (busy)  hi_cnt <= hi_cnt + 1'b1;
    else            hi_cnt <= '0;
  end

  AST_EOC_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (hi_cnt < CW'(NBITS))); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && (idx != '0)) |=> busy); // R4

endmodule

// File: rtl/sar_hold.sv
module sar_hold
  import sar_pkg::*;
#(
  parameter int unsigned NBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NBITS-1:0] code_in,
  input  logic             bipolar,
  output logic [NBITS-1:0] held,
  output logic [NBITS-1:0] twos
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= code_in;
  end

  always_comb begin
    sar_word_t w;
    w = sar_offset_to_twos(sar_word_t'(held), NBITS);
    twos = bipolar ? w[NBITS-1:0] : '0;
  end
endmodule

// File: rtl/sar_nibble_drv.sv
module sar_nibble_drv #(
  parameter int unsigned NBITS = 12,
  parameter int unsigned GRP   = 4
) (
  input  logic [NBITS-1:0]     data_in,
  input  logic [NBITS/GRP-1:0] oe_n,
  output logic [NBITS-1:0]     bus_q
);
  localparam int unsigned NGRP = NBITS / GRP;

  // group 0 owns the most significant nibble
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int unsigned LO = NBITS - GRP*(g+1);
    assign bus_q[LO +: GRP] = oe_n[g] ? {GRP{1'bz}} : data_in[LO +: GRP];
  end
endmodule

// File: rtl/sar_nibble_reg.sv
module sar_nibble_reg #(
  parameter int unsigned NBITS = 12,
  parameter int unsigned GRP   = 4,
  localparam int unsigned NGRP = NBITS / GRP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_ge,
  input  logic             bipolar,
  input  logic [NGRP-1:0]  oe_n,
  output logic [NBITS-1:0] dac_code,
  output logic             eoc,
  output logic [NBITS-1:0] bus_q,
  output logic [NBITS-1:0] twos_q
);
  logic             busy_w;
  logic             done_w;
  logic [NBITS-1:0] trial_w;
  logic [NBITS-1:0] final_w;
  logic [NBITS-1:0] held_w;
  logic [NBITS-1:0] bus_data_w;

  sar_seq #(.NBITS(NBITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_ge(cmp_ge),
    .busy(busy_w), .trial(trial_w), .done(done_w), .final_code(final_w)
  );

  sar_hold #(.NBITS(NBITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(done_w), .code_in(final_w),
    .bipolar(bipolar), .held(held_w), .twos(twos_q)
  );

  assign bus_data_w = busy_w ? trial_w : held_w;

  sar_nibble_drv #(.NBITS(NBITS), .GRP(GRP)) u_drv (
    .data_in(bus_data_w), .oe_n(oe_n), .bus_q(bus_q)
  );

  assign dac_code = trial_w;
  assign eoc      = busy_w;

  AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> (dac_code == {1'b1, {(NBITS-1){1'b0}}})); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |=> $stable(held_w)); // R5

  AST_LOAD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc) |-> (held_w[NBITS-1:1] == $past(dac_code[NBITS-1:1]))); // R3

  AST_TWOS_UNI: assert property (@(posedge clk) disable iff (!rst_n)
    !bipolar |-> (twos_q == '0)); // R8

endmodule

// File: tb/sim_sar_nibble_reg.sv
`timescale 1ns/1ps
module sim_sar_nibble_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        bipolar = 1'b0;
  logic [2:0]  oe_n = 3'b000;
  logic [11:0] dac_code;
  logic        eoc;
  wire  [11:0] bus_w;
  logic [11:0] twos_q;
  logic        cmp_ge;
  int          vin_r = 0;
  int          n_run = 0;
  int          n_fail = 0;
  int          cyc_cnt = 0;

  always #4 clk = ~clk;

  for (genvar i = 0; i < 12; i++) begin : g_pu
    pullup (bus_w[i]);
  end

  assign cmp_ge = (int'(dac_code) <= vin_r);

  sar_nibble_reg u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_ge(cmp_ge),
    .bipolar(bipolar), .oe_n(oe_n), .dac_code(dac_code), .eoc(eoc),
    .bus_q(bus_w), .twos_q(twos_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one conversion of v; returns cycles eoc was seen high.
  task automatic convert(input int v, input int pulse_at, output int cyc);
    vin_r = v;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (eoc === 1'b1 && cyc < 40) begin
      cyc++;
      if (cyc == pulse_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 eoc", 32'(eoc), 0);
    chk("R1 dac", 32'(dac_code), 0);
    chk("R1 twos", 32'(twos_q), 0);
    chk("R1 bus", 32'(bus_w), 0);
  endtask

  task automatic t_first_trial();
    vin_r = 100;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2 eoc rise", 32'(eoc), 1);
    chk("R2 msb trial", 32'(dac_code), 32'h800);
    chk("R6 live bus", 32'(bus_w), 32'h800);
    @(negedge clk);
    chk("R3 second trial", 32'(dac_code), 32'h400);
    chk("R6 live bus2", 32'(bus_w), 32'h400);
    while (eoc === 1'b1) @(negedge clk);
    chk("R3 result 100", 32'(bus_w), 100);
  endtask

  task automatic t_unipolar();
    int vals[5] = '{0, 4095, 1, 4094, 2730};
    bipolar = 1'b0;
    foreach (vals[k]) begin
      int c;
      convert(vals[k], 0, c);
      chk("R2 eoc length", 32'(c), 12);
      chk("R8 straight code", 32'(bus_w), 32'(vals[k]));
      chk("R8 twos zero", 32'(twos_q), 0);
    end
  endtask

  task automatic t_bipolar();
    int sv[4] = '{-2048, 0, 2047, -1};
    bipolar = 1'b1;
    foreach (sv[k]) begin
      int c;
      convert(sv[k] + 2048, 0, c);
      chk("R9 offset code", 32'(bus_w), 32'(sv[k] + 2048));
      chk("R9 twos view", 32'(twos_q), 32'(sv[k]) & 32'hFFF);
    end
    bipolar = 1'b0;
  endtask

  task automatic t_restart();
    int c;
    convert(1000, 5, c);
    chk("R4 length unchanged", 32'(c), 12);
    chk("R4 result unchanged", 32'(bus_w), 1000);
  endtask

  task automatic t_hold();
    int c;
    convert(1443, 0, c);
    vin_r = 4095;
    repeat (6) @(negedge clk);
    chk("R5 held under cmp high", 32'(bus_w), 1443);
    vin_r = 0;
    repeat (3) @(negedge clk);
    chk("R5 held under cmp low", 32'(bus_w), 1443);
  endtask

  task automatic t_groups();
    // result 0x5A3 from t_hold; released nibbles read F through pull-ups
    oe_n = 3'b110; #1 chk("R7 grp bits1-4", 32'(bus_w), 32'h5FF);
    oe_n = 3'b101; #1 chk("R7 grp bits5-8", 32'(bus_w), 32'hFAF);
    oe_n = 3'b011; #1 chk("R7 grp bits9-12", 32'(bus_w), 32'hFF3);
    oe_n = 3'b111; #1 chk("R7 all released", 32'(bus_w), 32'hFFF);
    oe_n = 3'b000; #1 chk("R7 all driven", 32'(bus_w), 32'h5A3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_first_trial();
    t_unipolar();
    t_bipolar();
    t_restart();
    t_hold();
    t_groups();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc_cnt);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule